// File: doc/BRIEF.md
# Sectioned Boot Image Loader

The loader takes a boot image as a stream of bytes and copies each section of it into memory through a word-wide write port. A section is an 8-byte header followed by its payload. The header holds a 32-bit byte count and then a 32-bit destination address, each sent most significant byte first. The loader packs the payload bytes into 32-bit words, with the lane order set by the byte addresses. It issues one write for each word touched and raises only the byte enables of the lanes that carry data. A header whose byte count is zero ends the image. The loader then reports the base address of the last section it loaded as the entry point and raises `done`.

Both data paths use valid/ready handshakes. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A word is delivered on an edge where `wr_valid` and `wr_ready` are both high. While a word is waiting on `wr_ready`, the write outputs stay fixed and `in_ready` stays low, so back-pressure from memory stops the input stream and no byte is lost. `done`, `err` and `entry` are plain level outputs. They hold until reset, and the loader takes no more input after the terminator.

Top module: `sect_loader`

## Requirements
- R1: Each header is 4 count bytes followed by 4 address bytes, each field most significant byte first. Header bytes never cause a write.
- R2: The payload byte at address A is placed in lane A mod 4. Lane 0 is `wr_data[31:24]` with `wr_be[3]`, and lane 3 is `wr_data[7:0]` with `wr_be[0]`. `wr_addr` is A with its two low bits cleared.
- R3: A word is issued when its lane 3 is filled or when the last byte of the section arrives. Only the lanes filled by that section are enabled, so a section that starts at an unaligned address begins at the matching lane.
- R4: A byte count of zero ends the image. No address bytes are consumed after it, and `in_ready` stays low from then until reset.
- R5: `done` rises only after the last payload word has been accepted. `entry` then equals the destination address of the last section that had a non-zero count, and `err` is low.
- R6: If the terminator is the first header, `done` rises with `err` high and `entry` equal to 0.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_be` hold their values and `in_ready` is low. Every payload byte is still written exactly once.
- R8: After reset, `in_ready` is high and `wr_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Image byte present |
| in_ready | output | 1 | Loader takes the byte this edge |
| in_data | input | 8 | Image byte |
| wr_valid | output | 1 | Write word present |
| wr_ready | input | 1 | Memory accepts the word this edge |
| wr_addr | output | 32 | Word-aligned write address |
| wr_data | output | 32 | Write data, lane 0 in the top byte |
| wr_be | output | 4 | Byte enables, bit 3 for lane 0 |
| done | output | 1 | Image finished and all writes drained |
| entry | output | 32 | Entry point, valid while done is high |
| err | output | 1 | Image ended with no section |

## Verification
A header counter that is off by one shifts every later field. That error shows up within one section as a write to a wrong address or as words with the wrong bytes. A fault in the remaining-count or lane logic shows up as wrong byte enables on the first or last word of a section, or as an extra or missing write that the scoreboard reports once the image completes. A fault in the stall path shows up as a repeated or missing word under random back-pressure, or as `done` rising while words are still expected. A wrong record of the last base address shows up only at the end, in `entry`.

// File: rtl/ldr_pkg.sv
`timescale 1ns/1ps
package ldr_pkg;
  typedef enum logic [1:0] {
    ST_CNT  = 2'd0,
    ST_DEST = 2'd1,
    ST_BODY = 2'd2,
    ST_END  = 2'd3
  } ldr_state_t;
endpackage

// File: rtl/ldr_parse.sv
`timescale 1ns/1ps
module ldr_parse
  import ldr_pkg::*;
#(
  parameter int HDR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             stall,
  output logic             in_ready,
  output logic             pay_fire,
  output logic [HDR_W-1:0] pay_addr,
  output logic             pay_last,
  output logic             end_seen,
  output logic [HDR_W-1:0] entry,
  output logic             err
);
  localparam int FB = HDR_W / 8;
  localparam int IW = (FB > 1) ? $clog2(FB) : 1;

  ldr_state_t       state;
  logic [IW-1:0]    idx;
  logic [HDR_W-9:0] sh;
  logic [HDR_W-1:0] field, len_q, rem, cur, base_q, entry_q;
  logic             seen, err_q, fire;

  assign in_ready = (state != ST_END) && !stall;
  assign fire     = in_valid && in_ready;
  assign field    = {sh, in_data};
  assign pay_fire = fire && (state == ST_BODY);
  assign pay_addr = cur;
  assign pay_last = (rem == HDR_W'(1));
  assign end_seen = (state == ST_END);
  assign entry    = entry_q;
  assign err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CNT;
      idx     <= '0;
      sh      <= '0;
      len_q   <= '0;
      rem     <= '0;
      cur     <= '0;
      base_q  <= '0;
      entry_q <= '0;
      seen    <= 1'b0;
      err_q   <= 1'b0;
    end else if (fire) begin
      unique case (state)
        ST_CNT, ST_DEST: begin
          sh <= {sh[HDR_W-17:0], in_data};
          if (idx == IW'(FB - 1)) begin
            idx <= '0;
            if (state == ST_CNT) begin
              if (field == '0) begin
                state   <= ST_END;
                entry_q <= seen ? base_q : '0;
                err_q   <= !seen;
              end else begin
                len_q <= field;
                state <= ST_DEST;
              end
            end else begin
              cur    <= field;
              base_q <= field;
              seen   <= 1'b1;
              rem    <= len_q;
              state  <= ST_BODY;
            end
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_BODY: begin
          cur <= cur + HDR_W'(1);
          rem <= rem - HDR_W'(1);
          if (pay_last) state <= ST_CNT;
        end
        default: state <= ST_END;
      endcase
    end
  end

  a_r4_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_END) |=> (state == ST_END));
  a_r3_body_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BODY) |-> (rem != '0));
endmodule

// File: rtl/ldr_pack.sv
`timescale 1ns/1ps
module ldr_pack #(
  parameter int HDR_W  = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pay_fire,
  input  logic [7:0]        pay_byte,
  input  logic [HDR_W-1:0]  pay_addr,
  input  logic              pay_last,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [HDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic              stall
);
  localparam int LANES = WORD_W / 8;
  localparam int LW    = $clog2(LANES);

  logic [WORD_W-1:0] acc_d, nxt_d;
  logic [LANES-1:0]  acc_be, nxt_be;
  logic [LW-1:0]     lane;
  logic              emit;

  assign lane = pay_addr[LW-1:0];
  assign emit = pay_fire && ((lane == LW'(LANES - 1)) || pay_last);
  assign stall = wr_valid && !wr_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (lane == LW'(g));
    assign nxt_d[(LANES-1-g)*8 +: 8] = hit ? pay_byte : acc_d[(LANES-1-g)*8 +: 8];
    assign nxt_be[LANES-1-g]         = hit | acc_be[LANES-1-g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_d    <= '0;
      acc_be   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else begin
      if (emit) begin
        wr_valid <= 1'b1;
        wr_addr  <= {pay_addr[HDR_W-1:LW], {LW{1'b0}}};
        wr_data  <= nxt_d;
        wr_be    <= nxt_be;
        acc_d    <= '0;
        acc_be   <= '0;
      end else begin
        if (wr_ready) wr_valid <= 1'b0;
        if (pay_fire) begin
          acc_d  <= nxt_d;
          acc_be <= nxt_be;
        end
      end
    end
  end

  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));
  a_r3_lanes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be != '0));
endmodule

// File: rtl/sect_loader.sv
`timescale 1ns/1ps
module sect_loader #(
  parameter int HDR_W  = 32,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [HDR_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic                done,
  output logic [HDR_W-1:0]    entry,
  output logic                err
);
  logic             stall, pay_fire, pay_last, end_seen;
  logic [HDR_W-1:0] pay_addr;

  ldr_parse #(.HDR_W(HDR_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .stall(stall), .in_ready(in_ready), .pay_fire(pay_fire),
    .pay_addr(pay_addr), .pay_last(pay_last), .end_seen(end_seen),
    .entry(entry), .err(err)
  );

  ldr_pack #(.HDR_W(HDR_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .pay_fire(pay_fire), .pay_byte(in_data),
    .pay_addr(pay_addr), .pay_last(pay_last), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .stall(stall)
  );

  assign done = end_seen && !wr_valid;

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready);
  a_r5_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_valid && !in_ready));
  a_r6_err_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (entry == '0));
endmodule

// File: tb/sim_sect_loader.sv
`timescale 1ns/1ps
module sim_sect_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data, entry;
  logic [3:0]  wr_be;
  logic        done, err;

  int tests = 0;
  int fails = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  bq[$];
  logic [67:0] exp_q[$];

  always #10 clk = ~clk;

  sect_loader u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .done(done), .entry(entry), .err(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= (bp_mode != 0) ? (lfsr[0] | lfsr[3]) & lfsr[5] : 1'b1;
  end

  // monitor: sample the handshake that the next rising edge will complete
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R1 unexpected write actual=%h/%h/%h expected=none", wr_addr, wr_data, wr_be);
        end else begin
          logic [67:0] e;
          e = exp_q.pop_front();
          check("R2 write address", wr_addr, e[67:36]);
          check("R2 write data", wr_data, e[35:4]);
          check("R3 byte enables", {28'd0, wr_be}, {28'd0, e[3:0]});
        end
      end
    end
  end

  function automatic logic [7:0] pat(int s, int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic add_section(logic [31:0] addr, int n, int s);
    logic [31:0] d = '0;
    logic [3:0]  be = '0;
    for (int k = 3; k >= 0; k--) bq.push_back(8'(n >> (8 * k)));
    for (int k = 3; k >= 0; k--) bq.push_back(addr[8*k +: 8]);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      logic [1:0]  ln;
      a  = addr + 32'(i);
      ln = a[1:0];
      bq.push_back(pat(s, i));
      d[(3 - ln) * 8 +: 8] = pat(s, i);
      be[3 - ln] = 1'b1;
      if (ln == 2'd3 || i == n - 1) begin
        exp_q.push_back({a[31:2], 2'b00, d, be});
        d = '0;
        be = '0;
      end
    end
  endtask

  task automatic add_term();
    for (int k = 0; k < 4; k++) bq.push_back(8'h00);
  endtask

  task automatic run_stream();
    while (bq.size() > 0) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = bq.pop_front();
      forever begin
        #2;
        if (in_ready) break;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      #3;
      t++;
    end
    check("R5 done raised", {31'd0, done}, 32'd1);
    check("R5 all words written before done", exp_q.size(), 0);
  endtask

  task automatic do_reset(int mode);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    bp_mode = mode;
    bq.delete();
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(0);
    #3;
    check("R8 in_ready after reset", {31'd0, in_ready}, 32'd1);
    check("R8 wr_valid after reset", {31'd0, wr_valid}, 32'd0);
    check("R8 done after reset", {31'd0, done}, 32'd0);
    check("R8 err after reset", {31'd0, err}, 32'd0);

    // aligned, unaligned and single-byte sections
    add_section(32'h0000_1000, 8, 1);
    add_section(32'h0000_2003, 6, 2);
    add_section(32'h0000_3002, 1, 3);
    add_term();
    run_stream();
    wait_done();
    check("R5 entry is last base", entry, 32'h0000_3002);
    check("R5 err low", {31'd0, err}, 32'd0);

    // R4: bytes after the terminator are refused and cause nothing
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h5A;
    repeat (4) @(negedge clk);
    #3;
    check("R4 in_ready low after end", {31'd0, in_ready}, 32'd0);
    check("R4 no write after end", {31'd0, wr_valid}, 32'd0);
    check("R4 entry unchanged", entry, 32'h0000_3002);
    in_valid = 1'b0;

    // R7: random back-pressure with mixed alignments
    do_reset(1);
    add_section(32'h0000_4001, 13, 4);
    add_section(32'h0000_0080, 4, 5);
    add_section(32'h0000_6000, 40, 7);
    add_section(32'h0000_5002, 3, 6);
    add_term();
    run_stream();
    wait_done();
    check("R7 entry under back-pressure", entry, 32'h0000_5002);

    // R1: multi-byte count and address, MSB first
    do_reset(1);
    add_section(32'h1234_5677, 261, 9);
    add_term();
    run_stream();
    wait_done();
    check("R1 entry from big-endian address", entry, 32'h1234_5677);

    // R6: terminator only
    do_reset(0);
    add_term();
    run_stream();
    repeat (2) @(negedge clk);
    #3;
    check("R6 done on empty image", {31'd0, done}, 32'd1);
    check("R6 err on empty image", {31'd0, err}, 32'd1);
    check("R6 entry zero", entry, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule